// File: doc/BRIEF.md
# Isosynchronous Serial Clock and Byte Shifter

This block runs one serial link in isosynchronous mode with a clock it makes itself. A divisor built from three byte-wide registers sets the serial clock period as a whole number of system clocks. The block drives that clock out on `sclk`. It shifts a transmit byte out on `txd`, launching each bit at a rising `sclk` edge. At each falling edge it samples `rxd`, so a byte comes in during the same frame.

A client loads the divisor bytes through a small write port. It then hands a byte over with a valid/ready handshake, and one frame of eight bit periods follows. The received byte comes back with a single-cycle strobe near the end of that frame. The control is a three-state machine:
- `ST_IDLE`: waiting. `sclk` low, `txd` high, ready asserted.
- `ST_HIGH`: the high phase of a bit. `txd` holds the bit.
- `ST_LOW`: the low phase of a bit.

The transitions are:
- accept: `ST_IDLE` to `ST_HIGH` on a handshake.
- fall: `ST_HIGH` to `ST_LOW` when the phase counter runs out; the sample is taken here.
- next-bit: `ST_LOW` to `ST_HIGH` when the counter runs out and bits remain.
- finish: `ST_LOW` to `ST_IDLE` after the eighth bit.

Top module: `iso_serial_unit`

## Requirements
- R1: Writing with `baud_we` high stores `baud_wdata` into one divisor byte. `baud_sel` 0 selects the low byte, 1 the middle byte and 2 the high byte, forming BAUD = {high, middle, low}. `baud_sel` 3 changes nothing. All three bytes reset to 0.
- R2: The serial clock period P is BAUD+1 system clocks when BAUD is at least 1, and 2 clocks when BAUD is 0.
- R3: When P is even, `sclk` is high for exactly P/2 clocks and low for exactly P/2 clocks in every bit.
- R4: When P is odd, `sclk` is high for (P+1)/2 clocks and low for (P-1)/2 clocks, so the high phase is one clock longer.
- R5: While idle, `sclk` is 0, `txd` is 1 and `tx_ready` is 1. This is also the state after reset.
- R6: A byte is accepted at a clock edge where `tx_valid` and `tx_ready` are both 1. In the next cycle `sclk` is 1, and `tx_ready` stays 0 for the 8·P cycles of the frame. A `tx_valid` raised during a frame is ignored.
- R7: Data leaves least significant bit first. Bit k appears on `txd` with the k-th rising `sclk` edge and is held for P clocks. `txd` returns to 1 when the frame ends.
- R8: `rxd` passes through two synchronizer flops. The value it had three clock edges before a falling `sclk` edge (in the register output) is taken as the next received bit, least significant bit first.
- R9: In the cycle after the eighth falling edge, `rx_valid` is 1 for exactly one cycle and `rx_data` holds the received byte.
- R10: A divisor write during a frame does not change that frame's timing. The new value applies from the next accepted byte.
- R11: Asserting the synchronous active-high `rst`, even in mid-frame, returns the block to the idle state of R5 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_we | input | 1 | Divisor byte write enable |
| baud_sel | input | 2 | Divisor byte select (0 low, 1 middle, 2 high) |
| baud_wdata | input | 8 | Divisor byte write data |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Ready to accept a transmit byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new received byte |
| sclk | output | 1 | Serial clock output |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
Let c count cycles after the accepting edge, with H = ceil(P/2). The results then fall due as follows:
- `sclk` and `txd` change in cycle c = 0, since both come from registers loaded at that edge.
- The falling edges come at c = kP+H.
- `rx_valid` shows at c = 7P+H.
- `tx_ready` returns at c = 8P.

The bench samples every output on the falling system clock edge and compares it, for every c of the frame, against a pattern worked out from P. It changes `rxd` only at c = kP+H−3, which is the one moment the synchronized sample for bit k reads, so any added or missing register stage shows up as a wrong received byte.

// File: rtl/iso_pkg.sv
package iso_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } iso_state_e;

endpackage

// File: rtl/iso_baud_regs.sv
module iso_baud_regs #(
    parameter int BAUD_W = 24,
    parameter int REG_W  = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [BAUD_W-1:0] baud
);
    localparam int NREG = BAUD_W / REG_W;

    for (genvar g = 0; g < NREG; g++) begin : g_byte
        logic [REG_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (we && sel == SEL_W'(g)) begin
                byte_q <= wdata;
            end
        end

        assign baud[g*REG_W +: REG_W] = byte_q;
    end
endmodule

// File: rtl/iso_phase_calc.sv
module iso_phase_calc #(
    parameter int BAUD_W = 24
) (
    input  logic [BAUD_W-1:0] baud,
    output logic [BAUD_W-1:0] hi_m1,
    output logic [BAUD_W-1:0] lo_m1
);
    localparam int PW = BAUD_W + 1;

    logic [PW-1:0] period;
    logic [PW-1:0] hi_len;
    logic [PW-1:0] lo_len;

    always_comb begin
        period = (baud == '0) ? PW'(2) : ({1'b0, baud} + PW'(1));
        // odd period: the extra clock goes to the high phase
        hi_len = (period + PW'(1)) >> 1;
        lo_len = period >> 1;
        hi_m1  = BAUD_W'(hi_len - PW'(1));
        lo_m1  = BAUD_W'(lo_len - PW'(1));
    end
endmodule

// File: rtl/iso_rx_sync.sv
module iso_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/iso_frame_fsm.sv
module iso_frame_fsm
    import iso_pkg::*;
#(
    parameter int BAUD_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BAUD_W-1:0] hi_m1_i,
    input  logic [BAUD_W-1:0] lo_m1_i,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              rx_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              txd
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    iso_state_e        state_q, state_d;
    logic [BAUD_W-1:0] cnt_q;
    logic [BAUD_W-1:0] hi_m1_q, lo_m1_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
    logic              cnt_zero, last_bit;

    assign cnt_zero = (cnt_q == '0);
    assign last_bit = (bit_q == BW'(DATA_W - 1));
    assign tx_ready = (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tx_valid) state_d = ST_HIGH;
            ST_HIGH: if (cnt_zero) state_d = ST_LOW;
            ST_LOW:  if (cnt_zero) state_d = last_bit ? ST_IDLE : ST_HIGH;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            hi_m1_q  <= '0;
            lo_m1_q  <= '0;
            bit_q    <= '0;
            tx_sh_q  <= '0;
            rx_sh_q  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            sclk     <= 1'b0;
            txd      <= 1'b1;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (tx_valid) begin
                        hi_m1_q <= hi_m1_i;
                        lo_m1_q <= lo_m1_i;
                        cnt_q   <= hi_m1_i;
                        bit_q   <= '0;
                        tx_sh_q <= tx_data >> 1;
                        txd     <= tx_data[0];
                        sclk    <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt_zero) begin
                        sclk    <= 1'b0;
                        cnt_q   <= lo_m1_q;
                        rx_sh_q <= {rx_in, rx_sh_q[DATA_W-1:1]};
                        if (last_bit) begin
                            rx_data  <= {rx_in, rx_sh_q[DATA_W-1:1]};
                            rx_valid <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (cnt_zero) begin
                        if (last_bit) begin
                            txd <= 1'b1;
                        end else begin
                            sclk    <= 1'b1;
                            txd     <= tx_sh_q[0];
                            tx_sh_q <= tx_sh_q >> 1;
                            cnt_q   <= hi_m1_q;
                            bit_q   <= bit_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: a frame starts only after a handshake in the previous cycle
    p_start_handshake_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIGH && $past(state_q) == ST_IDLE) |-> $past(tx_valid));

    // R7: within a frame txd only moves together with a rising sclk
    p_txd_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE && !$rose(sclk))
            |-> $stable(txd));

    // R10: latched phase lengths are frozen for the whole frame
    p_divisor_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
            |-> ($stable(hi_m1_q) && $stable(lo_m1_q)));
endmodule

// File: rtl/iso_serial_unit.sv
module iso_serial_unit #(
    parameter  int BAUD_W      = 24,
    parameter  int REG_W       = 8,
    parameter  int DATA_W      = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int NREG        = BAUD_W / REG_W,
    localparam int SEL_W       = (NREG > 1) ? $clog2(NREG + 1) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_we,
    input  logic [SEL_W-1:0]  baud_sel,
    input  logic [REG_W-1:0]  baud_wdata,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              txd,
    input  logic              rxd
);
    logic [BAUD_W-1:0] baud;
    logic [BAUD_W-1:0] hi_m1, lo_m1;
    logic              rx_s;

    iso_baud_regs #(.BAUD_W(BAUD_W), .REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (baud_we),
        .sel   (baud_sel),
        .wdata (baud_wdata),
        .baud  (baud)
    );

    iso_phase_calc #(.BAUD_W(BAUD_W)) u_phase (
        .baud  (baud),
        .hi_m1 (hi_m1),
        .lo_m1 (lo_m1)
    );

    iso_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    iso_frame_fsm #(.BAUD_W(BAUD_W), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .hi_m1_i  (hi_m1),
        .lo_m1_i  (lo_m1),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .rx_in    (rx_s),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .sclk     (sclk),
        .txd      (txd)
    );

    // R5: whenever the block is ready the line is quiet
    p_idle_lines_r5: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (!sclk && txd));

    // R9: the receive strobe never lasts two cycles
    p_rx_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

// File: tb/tb_iso_serial_unit.sv
`timescale 1ns/1ps
module tb_iso_serial_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_we = 1'b0;
    logic [1:0] baud_sel = 2'd0;
    logic [7:0] baud_wdata = 8'd0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       sclk;
    logic       txd;
    logic       rxd = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    iso_serial_unit dut (
        .clk(clk), .rst(rst), .baud_we(baud_we), .baud_sel(baud_sel),
        .baud_wdata(baud_wdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .sclk(sclk), .txd(txd), .rxd(rxd)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_byte(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        baud_we = 1'b1; baud_sel = sel; baud_wdata = val;
        @(negedge clk);
        baud_we = 1'b0;
    endtask

    task automatic write_baud(input logic [23:0] v);
        write_byte(2'd0, v[7:0]);
        write_byte(2'd1, v[15:8]);
        write_byte(2'd2, v[23:16]);
    endtask

    // R5 R11: idle outputs
    task automatic check_idle(input string tag);
        check(tx_ready && !sclk && txd && !rx_valid, tag,
              {tx_ready, sclk, txd, rx_valid}, 4'b1010);
    endtask

    // One frame, checked cycle by cycle. c = cycles after the accepting edge.
    task automatic run_frame(input logic [7:0] txb, input logic [7:0] rxb,
                             input int P, input bit mid_wr,
                             input logic [23:0] mid_val, input bit poke);
        int H = (P + 1) / 2;
        int e_clk = 0, e_tx = 0, e_rv = 0, e_rdy = 0;
        logic [31:0] a_clk = 0, x_clk = 0, a_tx = 0, x_tx = 0;
        logic [7:0]  got_rx = 8'h00;
        rxd = rxb[0];
        @(negedge clk);
        tx_data = txb; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        for (int c = 0; c < 8 * P; c++) begin
            if (sclk !== ((c % P) < H)) begin
                if (e_clk == 0) begin a_clk = {sclk, c[30:0]}; x_clk = {1'b0, c[30:0]}; end
                e_clk++;
            end
            if (txd !== txb[c / P]) begin
                if (e_tx == 0) begin a_tx = {txd, c[30:0]}; x_tx = {txb[c / P], c[30:0]}; end
                e_tx++;
            end
            if (rx_valid !== (c == 7 * P + H)) e_rv++;
            if (tx_ready !== 1'b0) e_rdy++;
            if (c == 7 * P + H) got_rx = rx_data;
            // bit k is read by the sample at c = kP+H, fed from the value set at c-3
            if (c + 3 >= H && ((c + 3 - H) % P) == 0 && (c + 3 - H) / P < 8)
                rxd = rxb[(c + 3 - H) / P];
            if (mid_wr) begin
                if (c == 3 * P)     begin baud_we = 1'b1; baud_sel = 2'd0; baud_wdata = mid_val[7:0];   end
                if (c == 3 * P + 1) begin baud_sel = 2'd1; baud_wdata = mid_val[15:8];  end
                if (c == 3 * P + 2) begin baud_sel = 2'd2; baud_wdata = mid_val[23:16]; end
                if (c == 3 * P + 3) baud_we = 1'b0;
            end
            if (poke) begin
                if (c == P)     begin tx_valid = 1'b1; tx_data = ~txb; end
                if (c == 2 * P) tx_valid = 1'b0;
            end
            @(negedge clk);
        end
        if (P % 2 == 1)
            check(e_clk == 0, "R2 R4 sclk shape (sclk,cycle)", a_clk, x_clk);
        else
            check(e_clk == 0, "R2 R3 sclk shape (sclk,cycle)", a_clk, x_clk);
        check(e_tx == 0, "R7 txd bits LSB first (txd,cycle)", a_tx, x_tx);
        check(e_rv == 0, "R9 rx_valid single strobe mismatches", e_rv, 0);
        check(got_rx == rxb, "R8 R9 received byte", got_rx, rxb);
        check(e_rdy == 0, "R6 tx_ready low during frame mismatches", e_rdy, 0);
        check_idle("R5 R6 idle after 8P cycles");
        repeat (3) @(negedge clk);
        check(!sclk && tx_ready, "R6 busy tx_valid ignored, no extra frame",
              {sclk, tx_ready}, 2'b01);
    endtask

    // High byte in use: P = 65537, then reset mid-frame
    task automatic high_byte_and_reset();
        int hi_n = 0, lo_n = 0;
        write_baud(24'h010000);
        @(negedge clk);
        tx_data = 8'h02; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        while (sclk) begin hi_n++; @(negedge clk); end
        while (!sclk) begin lo_n++; @(negedge clk); end
        check(hi_n == 32769, "R1 R4 high phase with high byte", hi_n, 32769);
        check(lo_n == 32768, "R1 R4 low phase with high byte", lo_n, 32768);
        check(txd == 1'b1, "R7 second bit on txd", txd, 1'b1);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R11 idle one edge after mid-frame reset");
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R11 idle after reset released");
        // divisor reset to 0 -> P = 2
        run_frame(8'h81, 8'h18, 2, 1'b0, 24'd0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", 190000, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check_idle("R5 reset state");
        // R1 R2: reset divisor 0 gives P = 2
        run_frame(8'hA5, 8'h3C, 2, 1'b0, 24'd0, 1'b0);
        // R2: BAUD = 1 also gives P = 2
        write_baud(24'd1);
        run_frame(8'h5A, 8'hC3, 2, 1'b0, 24'd0, 1'b0);
        // R3 even period, with busy poke (R6)
        write_baud(24'd5);
        run_frame(8'h96, 8'h69, 6, 1'b0, 24'd0, 1'b1);
        // R4 smallest odd period
        write_baud(24'd2);
        run_frame(8'h01, 8'h80, 3, 1'b0, 24'd0, 1'b0);
        // R4 odd period 7
        write_baud(24'd6);
        run_frame(8'hF0, 8'h0F, 7, 1'b0, 24'd0, 1'b0);
        // R1: select 3 writes nothing
        write_baud(24'd9);
        write_byte(2'd3, 8'h07);
        run_frame(8'h3E, 8'hE3, 10, 1'b0, 24'd0, 1'b0);
        // R1 middle byte: BAUD = 299
        write_baud(24'h00012B);
        run_frame(8'h6D, 8'hB2, 300, 1'b0, 24'd0, 1'b0);
        // R10: mid-frame write, current frame keeps P = 6, next uses 14
        write_baud(24'd5);
        run_frame(8'hC9, 8'h9C, 6, 1'b1, 24'd13, 1'b0);
        run_frame(8'h7E, 8'hE7, 14, 1'b0, 24'd0, 1'b0);
        high_byte_and_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule